// File: doc/BRIEF.md
# Triggered Transmit Waveform Player

This block keeps a set of ready-made transmit waveforms in a local sample memory. Before each waveform is needed, the host loads it through a single word-wide write port. A small table of slot descriptors records where each waveform starts in memory and how many samples it holds. Loading and sending are separate operations. Once a waveform is resident, a one-cycle trigger that names a slot streams it to the front-end. No further transfer is needed. Typical uses are an acknowledgement frame that must leave a fixed number of cycles after a received frame is validated, or a frame that is replayed repeatedly.

Each sample is 32 bits wide. The I part sits in bits 31:16 and the Q part in bits 15:0. During playback, the block outputs one sample on each cycle where the sample-clock enable is high, and it raises a valid strobe with that sample. When the last sample has gone out, the output drops back to zero and a one-cycle done pulse marks the end. Status outputs report a busy flag and two sticky error flags: one for a trigger that was refused and one for a host write that was refused.

The controller is a four-state machine:
- IDLE waits for a trigger.
- ARM latches the slot descriptor. It steps to PLAY, or straight to FINISH when the length is zero.
- PLAY emits samples. It steps to FINISH with the last one.
- FINISH clears the output, pulses done and returns to IDLE.

Top module: `wave_player`

## Requirements
- R1: After reset, the following are all low or zero: busy, both error flags, tx_valid, tx_done and tx_sample.
- R2: A host write with address bit 8 clear stores host_wdata into sample memory at host_addr[7:0].
- R3: A host write with address bit 8 set updates a descriptor. Bits 2:1 select the slot, and bit 0 selects the field: 0 is the start address (data bits 7:0), 1 is the length in samples (data bits 8:0).
- R4: While idle, a trigger is accepted and busy is high on the next cycle. With the sample enable held high, the first valid sample appears in the second cycle after the trigger edge.
- R5: During PLAY, each cycle with samp_en high outputs the next sample, starting at the slot's start address and wrapping at the end of memory. If samp_en was low on an edge, tx_valid is low after that edge.
- R6: After the stated number of samples, the next cycle shows tx_sample zero, tx_valid low, busy low and a one-cycle tx_done.
- R7: A slot of length zero emits no sample. It still produces tx_done two cycles after the trigger.
- R8: A trigger that arrives while busy is ignored: the running playback continues unchanged. The refused trigger sets stat_trig_err, which stays set until cleared.
- R9: While busy, the following host writes are dropped and set stat_wr_blocked: a sample write inside the active slot's address range, and a descriptor write to the active slot. Writes outside that range take effect.
- R10: Several waveforms remain resident at once, and any slot can be replayed later without reloading it.
- R11: cmd_clr clears both sticky flags. A new error in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host write address (bit 8 selects descriptor space) |
| host_wdata | input | 32 | Host write data |
| cmd_trig | input | 1 | Playback trigger, one cycle |
| cmd_slot | input | 2 | Slot to play |
| cmd_clr | input | 1 | Clear sticky error flags |
| samp_en | input | 1 | Sample-clock enable |
| stat_busy | output | 1 | Playback in progress |
| stat_trig_err | output | 1 | Sticky: trigger refused while busy |
| stat_wr_blocked | output | 1 | Sticky: host write refused |
| tx_sample | output | 32 | Output sample, I in 31:16, Q in 15:0 |
| tx_valid | output | 1 | Sample strobe |
| tx_done | output | 1 | One-cycle end-of-waveform pulse |

## Verification
The bench checks the exact start latency and end cycle, because an extra register in the trigger path would make the latency late or variable. It plays waveforms that wrap past the last memory address and a zero-length slot. A design that got these wrong would emit stale samples, or it would hang in PLAY with a length counter that has wrapped round. It paces the enable on alternate cycles, because a design that ignored the enable would emit too many strobes. It also fires a trigger and a write into the active slot during playback, then replays that slot. A design without the guard would restart mid-frame or corrupt the stored waveform.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_PLAY,
        ST_FINISH
    } wp_state_e;

    typedef struct packed {
        logic [15:0] i;
        logic [15:0] q;
    } wp_iq_t;

endpackage

// File: rtl/wp_sample_ram.sv
module wp_sample_ram
    import wp_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  wp_iq_t        wdata,
    input  logic [AW-1:0] raddr,
    output wp_iq_t        rdata
);

    wp_iq_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/wp_desc_table.sv
module wp_desc_table #(
    parameter int SLOTS = 4,
    parameter int AW    = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int LEN_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic              wfield,
    input  logic [LEN_W-1:0]  wdata,
    input  logic [SLOT_W-1:0] rslot,
    output logic [AW-1:0]     rstart,
    output logic [LEN_W-1:0]  rlen
);

    logic [AW-1:0]    start_q [SLOTS];
    logic [LEN_W-1:0] len_q   [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[s] <= '0;
                len_q[s]   <= '0;
            end else if (we && (wslot == SLOT_W'(s))) begin
                if (wfield) begin
                    len_q[s] <= wdata;
                end else begin
                    start_q[s] <= wdata[AW-1:0];
                end
            end
        end
    end

    assign rstart = start_q[rslot];
    assign rlen   = len_q[rslot];

endmodule

// File: rtl/wp_play_fsm.sv
module wp_play_fsm
    import wp_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int AW    = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int LEN_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [SLOT_W-1:0] trig_slot,
    input  logic              samp_en,
    input  logic [AW-1:0]     desc_start,
    input  logic [LEN_W-1:0]  desc_len,
    input  wp_iq_t            rd_data,
    output logic [SLOT_W-1:0] act_slot,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic              trig_reject,
    output wp_iq_t            tx_sample,
    output logic              tx_valid,
    output logic              tx_done
);

    wp_state_e        state, nxt;
    logic [AW-1:0]    ptr;
    logic [LEN_W-1:0] remain;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (trig) nxt = ST_ARM;
            ST_ARM:    nxt = (desc_len == '0) ? ST_FINISH : ST_PLAY;
            ST_PLAY:   if (samp_en && (remain == LEN_W'(1))) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_slot  <= '0;
            ptr       <= '0;
            remain    <= '0;
            tx_sample <= '0;
            tx_valid  <= 1'b0;
            tx_done   <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (trig) act_slot <= trig_slot;
                end
                ST_ARM: begin
                    ptr    <= desc_start;
                    remain <= desc_len;
                end
                ST_PLAY: begin
                    if (samp_en) begin
                        tx_sample <= rd_data;
                        tx_valid  <= 1'b1;
                        ptr       <= ptr + AW'(1);
                        remain    <= remain - LEN_W'(1);
                    end
                end
                ST_FINISH: begin
                    tx_sample <= '0;
                    tx_done   <= 1'b1;
                end
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign trig_reject = trig && (state != ST_IDLE);
    assign rd_addr     = ptr;

endmodule

// File: rtl/wave_player.sv
module wave_player
    import wp_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DEPTH = 256,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int AW     = $clog2(DEPTH),
    localparam int LEN_W  = AW + 1,
    localparam int HA_W   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              cmd_trig,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic              cmd_clr,
    input  logic              samp_en,
    output logic              stat_busy,
    output logic              stat_trig_err,
    output logic              stat_wr_blocked,
    output logic [31:0]       tx_sample,
    output logic              tx_valid,
    output logic              tx_done
);

    logic              is_desc;
    logic [SLOT_W-1:0] w_slot;
    logic              w_field;
    logic [AW-1:0]     w_off;
    logic              in_region;
    logic              hit_active;
    logic              wr_block;
    logic              ram_we, desc_we;

    logic [SLOT_W-1:0] act_slot;
    logic [AW-1:0]     cur_start;
    logic [LEN_W-1:0]  cur_len;
    logic [AW-1:0]     rd_addr;
    wp_iq_t            rd_data;
    wp_iq_t            out_s;
    logic              busy, trig_reject;

    // address decode and write guard against the slot being played
    assign is_desc    = host_addr[HA_W-1];
    assign w_slot     = host_addr[SLOT_W:1];
    assign w_field    = host_addr[0];
    assign w_off      = host_addr[AW-1:0] - cur_start;
    assign in_region  = ({1'b0, w_off} < cur_len);
    assign hit_active = busy && (is_desc ? (w_slot == act_slot) : in_region);
    assign wr_block   = host_we && hit_active;
    assign ram_we     = host_we && !is_desc && !hit_active;
    assign desc_we    = host_we && is_desc && !hit_active;

    wp_sample_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (host_addr[AW-1:0]),
        .wdata (wp_iq_t'(host_wdata)),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    wp_desc_table #(.SLOTS(SLOTS), .AW(AW)) u_desc (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (desc_we),
        .wslot  (w_slot),
        .wfield (w_field),
        .wdata  (host_wdata[LEN_W-1:0]),
        .rslot  (act_slot),
        .rstart (cur_start),
        .rlen   (cur_len)
    );

    wp_play_fsm #(.SLOTS(SLOTS), .AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (cmd_trig),
        .trig_slot   (cmd_slot),
        .samp_en     (samp_en),
        .desc_start  (cur_start),
        .desc_len    (cur_len),
        .rd_data     (rd_data),
        .act_slot    (act_slot),
        .rd_addr     (rd_addr),
        .busy        (busy),
        .trig_reject (trig_reject),
        .tx_sample   (out_s),
        .tx_valid    (tx_valid),
        .tx_done     (tx_done)
    );

    // sticky status, a new error wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_trig_err   <= 1'b0;
            stat_wr_blocked <= 1'b0;
        end else begin
            stat_trig_err   <= (stat_trig_err & ~cmd_clr) | trig_reject;
            stat_wr_blocked <= (stat_wr_blocked & ~cmd_clr) | wr_block;
        end
    end

    assign stat_busy = busy;
    assign tx_sample = out_s;

endmodule

// File: rtl/wp_checker.sv
module wp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic        cmd_trig,
    input logic        cmd_clr,
    input logic        samp_en,
    input logic        stat_busy,
    input logic        stat_trig_err,
    input logic        stat_wr_blocked,
    input logic [31:0] tx_sample,
    input logic        tx_valid,
    input logic        tx_done
);

    a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_trig && !stat_busy) |=> stat_busy);

    a_r5_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(samp_en));

    a_r5_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> stat_busy);

    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!stat_busy && !tx_valid && tx_sample == 32'd0));

    a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_trig && stat_busy) |=> stat_trig_err);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_trig_err && !cmd_clr) |=> stat_trig_err);

    a_r9_block_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_wr_blocked) |-> ($past(host_we) && $past(stat_busy)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr && !cmd_trig && !host_we) |=> (!stat_trig_err && !stat_wr_blocked));

endmodule

bind wave_player wp_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_we         (host_we),
    .cmd_trig        (cmd_trig),
    .cmd_clr         (cmd_clr),
    .samp_en         (samp_en),
    .stat_busy       (stat_busy),
    .stat_trig_err   (stat_trig_err),
    .stat_wr_blocked (stat_wr_blocked),
    .tx_sample       (tx_sample),
    .tx_valid        (tx_valid),
    .tx_done         (tx_done)
);

// File: tb/tb_wave_player.sv
`timescale 1ns/1ps
module tb_wave_player;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        cmd_trig = 1'b0;
    logic [1:0]  cmd_slot = '0;
    logic        cmd_clr = 1'b0;
    logic        samp_en = 1'b0;
    logic        stat_busy, stat_trig_err, stat_wr_blocked;
    logic [31:0] tx_sample;
    logic        tx_valid, tx_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    wave_player dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .cmd_trig(cmd_trig), .cmd_slot(cmd_slot),
        .cmd_clr(cmd_clr), .samp_en(samp_en), .stat_busy(stat_busy),
        .stat_trig_err(stat_trig_err), .stat_wr_blocked(stat_wr_blocked),
        .tx_sample(tx_sample), .tx_valid(tx_valid), .tx_done(tx_done)
    );

    typedef struct packed {
        logic [1:0] slot;
        logic [7:0] start;
        logic [8:0] len;
        logic       gap;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{slot: 2'd0, start: 8'd0,   len: 9'd5, gap: 1'b0},
        '{slot: 2'd1, start: 8'd20,  len: 9'd3, gap: 1'b0},
        '{slot: 2'd2, start: 8'd250, len: 9'd8, gap: 1'b0},
        '{slot: 2'd3, start: 8'd100, len: 9'd0, gap: 1'b0},
        '{slot: 2'd1, start: 8'd20,  len: 9'd3, gap: 1'b1},
        '{slot: 2'd0, start: 8'd0,   len: 9'd5, gap: 1'b1}
    };

    function automatic logic [31:0] pat(input int a);
        return {16'(a * 37 + 11), 16'(a ^ 32'h5A5A)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
                finish_run();
            end
        end
    end

    task automatic hwrite(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_desc(input int slot, input int start, input int len);
        hwrite(9'(9'h100 | (slot << 1)), 32'(start));          // R3 start field
        hwrite(9'(9'h100 | (slot << 1) | 1), 32'(len));        // R3 length field
    endtask

    // inj: 0 none, 1 trigger while busy, 2 write inside region,
    //      3 write outside region, 4 descriptor write to active slot, 5 trigger with clear
    task automatic play(input int slot, input int start, input int len, input int gap,
                        input int inj, input int ovr_addr, input logic [31:0] ovr_data);
        int k = 0;
        int first = -1;
        int done_cyc = -1;
        logic prev_en = 1'b1;
        logic en;
        @(negedge clk);
        cmd_trig = 1'b1; cmd_slot = 2'(slot); samp_en = 1'b1;
        for (int cyc = 0; cyc < 60 && done_cyc < 0; cyc++) begin
            @(negedge clk);
            if (cyc == 0) begin
                cmd_trig = 1'b0;
                chk("R4 busy after trigger", 32'(stat_busy), 32'd1);
            end
            if (cyc == 1) begin
                cmd_trig = 1'b0; host_we = 1'b0; cmd_clr = 1'b0;
            end
            if (tx_valid) begin
                int a = (start + k) % 256;
                if (!prev_en) chk("R5 strobe without enable", 32'd1, 32'd0);
                if (first < 0) first = cyc;
                chk("R5 sample value", tx_sample, (a == ovr_addr) ? ovr_data : pat(a));
                k++;
            end
            if (tx_done) begin
                done_cyc = cyc;
                chk("R6 sample zero at done", tx_sample, 32'd0);
                chk("R6 busy low at done", 32'(stat_busy), 32'd0);
            end
            if (cyc == 0) begin
                case (inj)
                    1: begin cmd_trig = 1'b1; cmd_slot = 2'((slot + 1) % 4); end
                    2: begin host_we = 1'b1; host_addr = 9'((start + 2) % 256); host_wdata = 32'hDEADBEEF; end
                    3: begin host_we = 1'b1; host_addr = 9'((start + len) % 256); host_wdata = ovr_data; end
                    4: begin host_we = 1'b1; host_addr = 9'(9'h100 | (slot << 1) | 1); host_wdata = 32'd1; end
                    5: begin cmd_trig = 1'b1; cmd_clr = 1'b1; cmd_slot = 2'(slot); end
                    default: ;
                endcase
            end
            en = (gap != 0) ? 1'((cyc % 2) == 1) : 1'b1;
            samp_en = en;
            prev_en = en;
        end
        samp_en = 1'b0;
        chk("R6 done seen", 32'(done_cyc >= 0), 32'd1);
        chk("R6 sample count", 32'(k), 32'(len));
        if (gap == 0) begin
            chk("R6 done cycle", 32'(done_cyc), 32'(len + 2));
            if (len > 0) chk("R4 first sample latency", 32'(first), 32'd2);
            else chk("R7 no sample for empty slot", 32'(first), 32'hFFFFFFFF);
        end
        @(negedge clk);
        chk("R6 done is one cycle", 32'(tx_done), 32'd0);
    endtask

    task automatic clear_flags();
        @(negedge clk); cmd_clr = 1'b1;
        @(negedge clk); cmd_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(stat_busy), 32'd0);
        chk("R1 trig_err", 32'(stat_trig_err), 32'd0);
        chk("R1 wr_blocked", 32'(stat_wr_blocked), 32'd0);
        chk("R1 valid", 32'(tx_valid), 32'd0);
        chk("R1 done", 32'(tx_done), 32'd0);
        chk("R1 sample", tx_sample, 32'd0);
        rst_n = 1'b1;

        // R2 load every sample location
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            host_we = 1'b1; host_addr = 9'(a); host_wdata = pat(a);
            @(negedge clk);
        end
        host_we = 1'b0;
        for (int i = 0; i < 4; i++) set_desc(VECS[i].slot, VECS[i].start, VECS[i].len);

        // vector walk: R4 R5 R6 R7 R10 (wrap in slot 2, paced enable, replay)
        for (int i = 0; i < 6; i++) begin
            play(VECS[i].slot, VECS[i].start, VECS[i].len, VECS[i].gap, 0, -1, 32'd0);
        end

        // R8 trigger while busy is refused and sticky
        play(0, 0, 5, 0, 1, -1, 32'd0);
        chk("R8 trig_err set", 32'(stat_trig_err), 32'd1);
        repeat (4) @(negedge clk);
        chk("R8 trig_err sticky", 32'(stat_trig_err), 32'd1);
        chk("R8 no stray playback", 32'(stat_busy), 32'd0);
        clear_flags();
        chk("R11 clear trig_err", 32'(stat_trig_err), 32'd0);

        // R9 write inside active region dropped; memory checked by replay
        play(0, 0, 5, 0, 2, -1, 32'd0);
        chk("R9 wr_blocked set", 32'(stat_wr_blocked), 32'd1);
        play(0, 0, 5, 0, 0, -1, 32'd0);
        clear_flags();
        chk("R11 clear wr_blocked", 32'(stat_wr_blocked), 32'd0);

        // R9 descriptor write to the active slot dropped
        play(0, 0, 5, 0, 4, -1, 32'd0);
        chk("R9 desc write blocked", 32'(stat_wr_blocked), 32'd1);
        play(0, 0, 5, 0, 0, -1, 32'd0);
        clear_flags();

        // R9 write outside region takes effect
        play(0, 0, 5, 0, 3, -1, 32'hCAFE0005);
        chk("R9 outside write not flagged", 32'(stat_wr_blocked), 32'd0);
        set_desc(3, 5, 1);
        play(3, 5, 1, 0, 0, 5, 32'hCAFE0005);

        // R10 earlier slots still resident
        play(2, 250, 8, 0, 0, -1, 32'd0);

        // R11 new error wins over clear in same cycle
        play(1, 20, 3, 0, 5, -1, 32'd0);
        chk("R11 set beats clear", 32'(stat_trig_err), 32'd1);
        clear_flags();
        chk("R11 final clear", 32'(stat_trig_err), 32'd0);

        finish_run();
    end

endmodule